// File: doc/BRIEF.md
# Guarded Register File

This block holds the sixteen 32-bit architectural registers of a small processor core. It offers two combinational read ports and one write port. A privilege input qualifies every write. The register space falls into five classes:

- a constant-zero slot;
- seven general-purpose registers;
- four unprotected special registers: status flags, instruction pointer, stack pointer and frame base pointer;
- three protected registers: page-table base, interrupt vector table base and machine control;
- one reserved slot.

When user-mode code tries to write a protected register, the block drops the write and raises a one-cycle protection-fault strobe. Trap logic elsewhere in the core turns that strobe into an exception. A write that takes effect in a cycle is also visible on a read port that names the same register in that cycle. A decode stage can therefore read the operand it is about to overwrite without a stall.

Top module: `guarded_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to zero and clears the fault strobe; after reset every index reads zero on both ports.
- R2: Index 0 always reads zero; writes to it are discarded and are not forwarded to a read port.
- R3: Indices 1 to 11 (general-purpose 1–7, flags 8, instruction pointer 9, stack pointer 10, base pointer 11) accept writes in either privilege state (priv_i = 0 user, 1 supervisor).
- R4: Indices 12 (page-table base), 13 (vector table base) and 14 (control) accept writes when priv_i is 1.
- R5: A write to index 12, 13 or 14 with priv_i at 0 leaves the register at its previous value.
- R6: gp_fault_o is 1 in the cycle after each write request that R5 blocks, and 0 after any cycle with no such request. Consecutive blocked writes give consecutive high cycles.
- R7: When a write takes effect and a read port addresses the same index in the same cycle, that port returns the new data combinationally.
- R8: A blocked or discarded write is not forwarded; the read port returns the stored value.
- R9: Index 15 is reserved. It always reads zero, and writes to it are discarded in either privilege state without a fault.
- R10: The two read ports are independent and may address any pair of indices, including the same one.
- R11: With we_i low, no register changes and no fault is raised, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| priv_i | input | 1 | 1 = supervisor, 0 = user |
| we_i | input | 1 | Write request |
| waddr_i | input | 4 | Write index |
| wdata_i | input | 32 | Write data |
| raddr_a_i | input | 4 | Read port A index |
| rdata_a_o | output | 32 | Read port A data |
| raddr_b_i | input | 4 | Read port B index |
| rdata_b_o | output | 32 | Read port B data |
| gp_fault_o | output | 1 | Protection-fault strobe |

## Verification
A blocked write that corrupts storage can only be seen when that index is read again. The vectors therefore read each protected register in the same cycle as the faulting write and again at a later point, where a leaked write appears as wrong data. Wrong forwarding shows up in the write cycle itself, because the read ports are combinational. A wrong fault decision shows one cycle later on gp_fault_o. Back-to-back faulting writes and a user-mode write to the reserved slot separate a level output from a true strobe and find a protection range that is off by one.

// File: rtl/grf_pkg.sv
package grf_pkg;

    // Fixed register indices (architectural, decoded by neighbouring logic)
    localparam int unsigned IDX_ZERO  = 0;
    localparam int unsigned IDX_GPR_LO = 1;
    localparam int unsigned IDX_GPR_HI = 7;
    localparam int unsigned IDX_FLAGS = 8;
    localparam int unsigned IDX_IP    = 9;
    localparam int unsigned IDX_SP    = 10;
    localparam int unsigned IDX_BP    = 11;
    localparam int unsigned IDX_PTB   = 12;
    localparam int unsigned IDX_VTB   = 13;
    localparam int unsigned IDX_CTL   = 14;
    localparam int unsigned IDX_RSVD  = 15;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_GPR,
        CLS_SPECIAL,
        CLS_PROT,
        CLS_RSVD
    } reg_class_e;

    function automatic reg_class_e classify(input logic [7:0] idx);
        reg_class_e c;
        if (idx == 8'(IDX_ZERO))          c = CLS_ZERO;
        else if (idx <= 8'(IDX_GPR_HI))   c = CLS_GPR;
        else if (idx <= 8'(IDX_BP))       c = CLS_SPECIAL;
        else if (idx <= 8'(IDX_CTL))      c = CLS_PROT;
        else                              c = CLS_RSVD;
        return c;
    endfunction

    // Classes whose storage is never written and always reads zero
    function automatic logic reads_zero(input reg_class_e c);
        return (c == CLS_ZERO) || (c == CLS_RSVD);
    endfunction

endpackage

// File: rtl/grf_guard.sv
module grf_guard
    import grf_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             priv_i,
    input  logic             we_i,
    input  logic [IDX_W-1:0] waddr_i,
    output logic             commit_o,
    output logic             fault_o
);

    typedef struct packed {
        logic fault;
    } guard_state_t;

    guard_state_t st_d, st_q;
    reg_class_e   wcls;
    logic         deny;

    always_comb begin
        wcls     = classify(8'(waddr_i));
        deny     = we_i && (wcls == CLS_PROT) && !priv_i;
        commit_o = we_i && !deny && !reads_zero(wcls);
        st_d       = st_q;
        st_d.fault = deny;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fault_o = st_q.fault;

endmodule

// File: rtl/grf_store.sv
module grf_store #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          commit_i,
    input  logic [IDX_W-1:0]              waddr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    output logic [DEPTH-1:0][DATA_W-1:0]  regs_o
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] regs;
    } store_state_t;

    store_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit_i) begin
            st_d.regs[waddr_i] = wdata_i;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign regs_o = st_q.regs;

endmodule

// File: rtl/grf_rdport.sv
module grf_rdport
    import grf_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][DATA_W-1:0] regs_i,
    input  logic [IDX_W-1:0]             raddr_i,
    input  logic                         commit_i,
    input  logic [IDX_W-1:0]             waddr_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic [DATA_W-1:0]            rdata_o
);

    reg_class_e rcls;

    always_comb begin
        rcls = classify(8'(raddr_i));
        if (reads_zero(rcls)) begin
            rdata_o = '0;
        end else if (commit_i && (waddr_i == raddr_i)) begin
            rdata_o = wdata_i;
        end else begin
            rdata_o = regs_i[raddr_i];
        end
    end

endmodule

// File: rtl/guarded_regfile.sv
module guarded_regfile #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned N_RD   = 2,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              priv_i,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  raddr_a_i,
    output logic [DATA_W-1:0] rdata_a_o,
    input  logic [IDX_W-1:0]  raddr_b_i,
    output logic [DATA_W-1:0] rdata_b_o,
    output logic              gp_fault_o
);

    logic                         commit;
    logic [DEPTH-1:0][DATA_W-1:0] regs;
    logic [N_RD-1:0][IDX_W-1:0]   raddr;
    logic [N_RD-1:0][DATA_W-1:0]  rdata;

    grf_guard #(.IDX_W(IDX_W)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .priv_i   (priv_i),
        .we_i     (we_i),
        .waddr_i  (waddr_i),
        .commit_o (commit),
        .fault_o  (gp_fault_o)
    );

    grf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .commit_i (commit),
        .waddr_i  (waddr_i),
        .wdata_i  (wdata_i),
        .regs_o   (regs)
    );

    assign raddr[0] = raddr_a_i;
    assign raddr[1] = raddr_b_i;

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        grf_rdport #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd (
            .regs_i   (regs),
            .raddr_i  (raddr[p]),
            .commit_i (commit),
            .waddr_i  (waddr_i),
            .wdata_i  (wdata_i),
            .rdata_o  (rdata[p])
        );
    end

    assign rdata_a_o = rdata[0];
    assign rdata_b_o = rdata[1];

endmodule

// File: rtl/guarded_regfile_chk.sv
module guarded_regfile_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              priv_i,
    input logic              we_i,
    input logic [IDX_W-1:0]  waddr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [IDX_W-1:0]  raddr_a_i,
    input logic [DATA_W-1:0] rdata_a_o,
    input logic [IDX_W-1:0]  raddr_b_i,
    input logic [DATA_W-1:0] rdata_b_o,
    input logic              gp_fault_o
);

    logic bad_wr;
    logic live_wr;

    assign bad_wr  = we_i && !priv_i && (waddr_i >= IDX_W'(12)) && (waddr_i <= IDX_W'(14));
    assign live_wr = we_i && (waddr_i != '0) && (waddr_i != IDX_W'(15)) &&
                     (priv_i || (waddr_i < IDX_W'(12)));

    assert_zero_a_R2: assert property (@(posedge clk) disable iff (rst)
        (raddr_a_i == '0) |-> (rdata_a_o == '0));
    assert_zero_b_R2: assert property (@(posedge clk) disable iff (rst)
        (raddr_b_i == '0) |-> (rdata_b_o == '0));
    assert_rsvd_a_R9: assert property (@(posedge clk) disable iff (rst)
        (raddr_a_i == IDX_W'(15)) |-> (rdata_a_o == '0));
    assert_fault_set_R6: assert property (@(posedge clk) disable iff (rst)
        bad_wr |=> gp_fault_o);
    assert_fault_clr_R6: assert property (@(posedge clk) disable iff (rst)
        !bad_wr |=> !gp_fault_o);
    assert_forward_a_R7: assert property (@(posedge clk) disable iff (rst)
        (live_wr && (waddr_i == raddr_a_i)) |-> (rdata_a_o == wdata_i));
    assert_forward_b_R7: assert property (@(posedge clk) disable iff (rst)
        (live_wr && (waddr_i == raddr_b_i)) |-> (rdata_b_o == wdata_i));
    assert_blocked_R5: assert property (@(posedge clk) disable iff (rst)
        (bad_wr && (raddr_a_i == waddr_i)) |=>
        (we_i || !$stable(raddr_a_i) || $stable(rdata_a_o)));

endmodule

bind guarded_regfile guarded_regfile_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .priv_i     (priv_i),
    .we_i       (we_i),
    .waddr_i    (waddr_i),
    .wdata_i    (wdata_i),
    .raddr_a_i  (raddr_a_i),
    .rdata_a_o  (rdata_a_o),
    .raddr_b_i  (raddr_b_i),
    .rdata_b_o  (rdata_b_o),
    .gp_fault_o (gp_fault_o)
);

// File: tb/guarded_regfile_tb.sv
module guarded_regfile_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int  N_VEC      = 18;

    typedef struct packed {
        logic        priv;
        logic        we;
        logic [3:0]  wa;
        logic [31:0] wd;
        logic [3:0]  ra;
        logic [3:0]  rb;
        logic [31:0] ea;
        logic [31:0] eb;
        logic        ef;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [N_VEC] = '{
        // R3 R7: user write GPR1, forwarded on A
        '{1'b0, 1'b1, 4'd1,  32'h11111111, 4'd1,  4'd0,  32'h11111111, 32'h0,        1'b0, 8'd7},
        // R10: both ports, different indices
        '{1'b0, 1'b1, 4'd2,  32'h22222222, 4'd1,  4'd2,  32'h11111111, 32'h22222222, 1'b0, 8'd10},
        // R2: write to zero slot not forwarded
        '{1'b0, 1'b1, 4'd0,  32'hDEADBEEF, 4'd0,  4'd1,  32'h0,        32'h11111111, 1'b0, 8'd2},
        // R2: zero slot stays zero
        '{1'b0, 1'b0, 4'd0,  32'h0,        4'd0,  4'd2,  32'h0,        32'h22222222, 1'b0, 8'd2},
        // R8 R6: user write to page-table base blocked, faults
        '{1'b0, 1'b1, 4'd12, 32'hAAAA0001, 4'd12, 4'd7,  32'h0,        32'h0,        1'b1, 8'd8},
        // R5: still unchanged
        '{1'b0, 1'b0, 4'd12, 32'h0,        4'd12, 4'd12, 32'h0,        32'h0,        1'b0, 8'd5},
        // R4: supervisor write accepted
        '{1'b1, 1'b1, 4'd12, 32'hAAAA0001, 4'd12, 4'd0,  32'hAAAA0001, 32'h0,        1'b0, 8'd4},
        // R6: user write to vector table base
        '{1'b0, 1'b1, 4'd13, 32'h5,        4'd13, 4'd12, 32'h0,        32'hAAAA0001, 1'b1, 8'd6},
        // R6: back-to-back fault on control
        '{1'b0, 1'b1, 4'd14, 32'h6,        4'd14, 4'd12, 32'h0,        32'hAAAA0001, 1'b1, 8'd6},
        // R5: 13 and 14 unchanged
        '{1'b0, 1'b0, 4'd0,  32'h0,        4'd14, 4'd13, 32'h0,        32'h0,        1'b0, 8'd5},
        // R4: supervisor control write
        '{1'b1, 1'b1, 4'd14, 32'hC0C0C0C0, 4'd14, 4'd1,  32'hC0C0C0C0, 32'h11111111, 1'b0, 8'd4},
        // R9: supervisor write to reserved slot discarded
        '{1'b1, 1'b1, 4'd15, 32'hFFFFFFFF, 4'd15, 4'd15, 32'h0,        32'h0,        1'b0, 8'd9},
        // R9: user write to reserved slot, no fault
        '{1'b0, 1'b1, 4'd15, 32'h1,        4'd15, 4'd14, 32'h0,        32'hC0C0C0C0, 1'b0, 8'd9},
        // R3: user write to flags
        '{1'b0, 1'b1, 4'd8,  32'h80808080, 4'd8,  4'd10, 32'h80808080, 32'h0,        1'b0, 8'd3},
        // R11: we low, nothing changes
        '{1'b0, 1'b0, 4'd8,  32'h12345678, 4'd8,  4'd2,  32'h80808080, 32'h22222222, 1'b0, 8'd11},
        // R3: base pointer via port B forward
        '{1'b1, 1'b1, 4'd11, 32'h0B0B0B0B, 4'd8,  4'd11, 32'h80808080, 32'h0B0B0B0B, 1'b0, 8'd3},
        // R5 R8: blocked write keeps old protected value
        '{1'b0, 1'b1, 4'd12, 32'h0,        4'd12, 4'd14, 32'hAAAA0001, 32'hC0C0C0C0, 1'b1, 8'd5},
        // R10: same index on both ports with forward
        '{1'b0, 1'b1, 4'd7,  32'h77777777, 4'd7,  4'd7,  32'h77777777, 32'h77777777, 1'b0, 8'd10}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        priv_i = 1'b0;
    logic        we_i = 1'b0;
    logic [3:0]  waddr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [3:0]  raddr_a_i = '0;
    logic [31:0] rdata_a_o;
    logic [3:0]  raddr_b_i = '0;
    logic [31:0] rdata_b_o;
    logic        gp_fault_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    guarded_regfile u_dut (
        .clk        (clk),
        .rst        (rst),
        .priv_i     (priv_i),
        .we_i       (we_i),
        .waddr_i    (waddr_i),
        .wdata_i    (wdata_i),
        .raddr_a_i  (raddr_a_i),
        .rdata_a_o  (rdata_a_o),
        .raddr_b_i  (raddr_b_i),
        .rdata_b_o  (rdata_b_o),
        .gp_fault_o (gp_fault_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        string tag;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state on all indices and fault low
        #1;
        check("R1 fault", 32'(gp_fault_o), 32'h0);
        for (int i = 0; i < 16; i++) begin
            raddr_a_i = 4'(i);
            raddr_b_i = 4'(15 - i);
            #1;
            check("R1 port A", rdata_a_o, 32'h0);
            check("R1 port B", rdata_b_o, 32'h0);
        end

        // Vector table walk
        for (int v = 0; v < N_VEC; v++) begin
            @(negedge clk);
            priv_i    = VECS[v].priv;
            we_i      = VECS[v].we;
            waddr_i   = VECS[v].wa;
            wdata_i   = VECS[v].wd;
            raddr_a_i = VECS[v].ra;
            raddr_b_i = VECS[v].rb;
            tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
            #1;
            check({tag, " A"}, rdata_a_o, VECS[v].ea);
            check({tag, " B"}, rdata_b_o, VECS[v].eb);
            @(posedge clk);
            #1;
            check({tag, " fault (R6)"}, 32'(gp_fault_o), 32'(VECS[v].ef));
        end

        // R6: fault drops when the next cycle has no blocked write
        @(negedge clk);
        we_i = 1'b0;
        @(posedge clk);
        #1;
        check("R6 strobe ends", 32'(gp_fault_o), 32'h0);

        // R11: we low on protected index in user mode gives no fault
        @(negedge clk);
        priv_i = 1'b0; we_i = 1'b0; waddr_i = 4'd13; wdata_i = 32'h99;
        raddr_a_i = 4'd13;
        @(posedge clk);
        #1;
        check("R11 no fault", 32'(gp_fault_o), 32'h0);
        check("R11 no change", rdata_a_o, 32'h0);

        // R1: mid-run reset clears written registers
        @(negedge clk);
        rst = 1'b1; we_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) begin
            raddr_a_i = 4'(i);
            raddr_b_i = 4'(i);
            #1;
            check("R1 after rerun A", rdata_a_o, 32'h0);
            check("R1 after rerun B", rdata_b_o, 32'h0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule